// File: doc/BRIEF.md
# Per-Process Memory Node Wake Predictor

This block tracks, for every process slot and every memory node, how many pages of that node are mapped into that process. A node counts as part of a process's active set while its page count is nonzero. The operating system reports page mappings and unmappings to the block, one event per cycle. Each event names a process slot and a node.

At a context switch the block receives two process slots: the process about to run and the one expected to run after it. One cycle later it presents a wake mask. The mask is the union of the active sets of those two processes. The power controller uses it to raise the named nodes from the deep low-power state to the ready state while the switch overhead is still under way. The wake mask holds its value until the next switch.

A page event and a switch may arrive in the same cycle. In that case the page event is applied first, and the mask reflects the updated counts. Counters saturate at their maximum value. An unmap on a count of zero changes nothing and raises a one-cycle error pulse.

Top module: `node_wake_tracker`

## Requirements
- R1: While reset is asserted, and after it is released, `wake_valid`, `wake_mask` and `unmap_err` are 0 and every page count is 0.
- R2: A map event (`pg_valid`=1, `pg_unmap`=0) increments the count of (`pg_proc`, `pg_node`). The first map of a node puts bit `pg_node` of the mask into that process's active set.
- R3: An unmap event (`pg_unmap`=1) decrements the count. A node stays active until the number of unmaps equals the number of maps, and the node leaves the active set when the count returns to 0.
- R4: A count at its maximum value 2^CNT_W-1 is unchanged by further maps. After saturation, exactly 2^CNT_W-1 unmaps return the node to inactive.
- R5: An unmap of a zero count leaves all counts unchanged. It drives `unmap_err` high for exactly the cycle after the event.
- R6: A switch (`sw_valid`=1) produces `wake_valid`=1 in the following cycle. In that same cycle, `wake_mask` bit n is 1 exactly when node n is active for `sw_next` or for `sw_after`.
- R7: In a cycle following no switch, `wake_valid` is 0 and `wake_mask` keeps its previous value.
- R8: When a page event and a switch are sampled in the same cycle, the wake mask reflects the count after that page event.
- R9: Counts are kept separately per process slot. An event on one slot never changes the active set of another slot.
- R10: A switch whose `sw_next` equals `sw_after` yields that single process's active set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pg_valid | input | 1 | Page event present this cycle |
| pg_unmap | input | 1 | 0 = map (increment), 1 = unmap (decrement) |
| pg_proc | input | PID_W | Process slot of the page event |
| pg_node | input | NODE_W | Memory node of the page event |
| sw_valid | input | 1 | Context switch present this cycle |
| sw_next | input | PID_W | Slot of the process about to run |
| sw_after | input | PID_W | Slot of the process expected to run next after it |
| wake_mask | output | NUM_NODES | Nodes to raise from deep sleep; bit n is node n |
| wake_valid | output | 1 | One-cycle strobe marking a fresh wake mask |
| unmap_err | output | 1 | One-cycle pulse after an unmap of a zero count |

## Verification
Saturation is the hardest state to reach from the ports, because the default 16-bit counters would need 65535 maps. The bench therefore builds the block with 3-bit counters. It maps one node nine times, then unmaps it seven times with a switch after each step. The node must disappear from the mask exactly at the seventh unmap, and one more unmap must then raise the error. The same-cycle event and switch ordering is exercised in both directions. A first map of a node arrives together with a switch, and a last unmap of a node also arrives together with a switch.

// File: rtl/nwt_pkg.sv
package nwt_pkg;
  typedef enum logic {
    PG_MAP   = 1'b0,
    PG_UNMAP = 1'b1
  } pg_kind_e;

  function automatic int unsigned idx_w(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/nwt_count_cell.sv
module nwt_count_cell #(
  parameter int unsigned CNT_W = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic inc,
  input  logic dec,
  output logic active_nxt,
  output logic underflow
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_d     = cnt_q;
    underflow = 1'b0;
    if (inc) begin
      if (cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
    end else if (dec) begin
      if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
      else underflow = 1'b1;
    end
  end

  assign cnt_en     = inc | dec;
  assign active_nxt = (cnt_d != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  p_step_up_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && cnt_q != CNT_MAX) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));

  p_step_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !inc && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX));

  p_no_underflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !inc && cnt_q == '0) |=> (cnt_q == '0));

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc && !dec) |=> $stable(cnt_q));
endmodule

// File: rtl/nwt_count_bank.sv
module nwt_count_bank #(
  parameter int unsigned NUM_PROCS = 8,
  parameter int unsigned NUM_NODES = 16,
  parameter int unsigned CNT_W     = 16,
  localparam int unsigned PID_W    = nwt_pkg::idx_w(NUM_PROCS),
  localparam int unsigned NODE_W   = nwt_pkg::idx_w(NUM_NODES)
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  pg_valid,
  input  logic                                  pg_unmap,
  input  logic [PID_W-1:0]                      pg_proc,
  input  logic [NODE_W-1:0]                     pg_node,
  output logic [NUM_PROCS-1:0][NUM_NODES-1:0]   active_nxt,
  output logic                                  underflow
);
  import nwt_pkg::*;

  pg_kind_e kind;
  logic [NUM_PROCS*NUM_NODES-1:0] uf_vec;

  assign kind = pg_kind_e'(pg_unmap);

  for (genvar p = 0; p < NUM_PROCS; p++) begin : g_proc
    for (genvar n = 0; n < NUM_NODES; n++) begin : g_node
      logic hit;
      assign hit = pg_valid && (pg_proc == PID_W'(p)) && (pg_node == NODE_W'(n));

      nwt_count_cell #(.CNT_W(CNT_W)) u_cell (
        .clk        (clk),
        .rst_n      (rst_n),
        .inc        (hit && (kind == PG_MAP)),
        .dec        (hit && (kind == PG_UNMAP)),
        .active_nxt (active_nxt[p][n]),
        .underflow  (uf_vec[p*NUM_NODES+n])
      );
    end
  end

  assign underflow = |uf_vec;

  p_single_uf_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(uf_vec));
endmodule

// File: rtl/nwt_wake_merge.sv
module nwt_wake_merge #(
  parameter int unsigned NUM_PROCS = 8,
  parameter int unsigned NUM_NODES = 16,
  localparam int unsigned PID_W    = nwt_pkg::idx_w(NUM_PROCS)
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic [NUM_PROCS-1:0][NUM_NODES-1:0] active_nxt,
  input  logic                                sw_valid,
  input  logic [PID_W-1:0]                    sw_next,
  input  logic [PID_W-1:0]                    sw_after,
  output logic [NUM_NODES-1:0]                wake_mask,
  output logic                                wake_valid
);
  logic [NUM_NODES-1:0] row_next;
  logic [NUM_NODES-1:0] row_after;
  logic [NUM_NODES-1:0] mask_d;
  logic                 valid_d;

  always_comb begin
    row_next  = '0;
    row_after = '0;
    for (int p = 0; p < NUM_PROCS; p++) begin
      if (sw_next == PID_W'(p))  row_next  = active_nxt[p];
      if (sw_after == PID_W'(p)) row_after = active_nxt[p];
    end
    mask_d  = wake_mask;
    valid_d = sw_valid;
    if (sw_valid) mask_d = row_next | row_after;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wake_mask  <= '0;
      wake_valid <= 1'b0;
    end else begin
      wake_mask  <= mask_d;
      wake_valid <= valid_d;
    end
  end

  p_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sw_valid |=> wake_valid);

  p_mask_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_valid |=> (!wake_valid && $stable(wake_mask)));
endmodule

// File: rtl/node_wake_tracker.sv
module node_wake_tracker #(
  parameter int unsigned NUM_PROCS = 8,
  parameter int unsigned NUM_NODES = 16,
  parameter int unsigned CNT_W     = 16,
  localparam int unsigned PID_W    = nwt_pkg::idx_w(NUM_PROCS),
  localparam int unsigned NODE_W   = nwt_pkg::idx_w(NUM_NODES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 pg_valid,
  input  logic                 pg_unmap,
  input  logic [PID_W-1:0]     pg_proc,
  input  logic [NODE_W-1:0]    pg_node,
  input  logic                 sw_valid,
  input  logic [PID_W-1:0]     sw_next,
  input  logic [PID_W-1:0]     sw_after,
  output logic [NUM_NODES-1:0] wake_mask,
  output logic                 wake_valid,
  output logic                 unmap_err
);
  logic [1:0] rst_sync_q;
  logic       rst_i;
  logic [NUM_PROCS-1:0][NUM_NODES-1:0] active_nxt;
  logic       underflow;
  logic       err_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i = rst_sync_q[1];

  nwt_count_bank #(
    .NUM_PROCS(NUM_PROCS), .NUM_NODES(NUM_NODES), .CNT_W(CNT_W)
  ) u_bank (
    .clk        (clk),
    .rst_n      (rst_i),
    .pg_valid   (pg_valid),
    .pg_unmap   (pg_unmap),
    .pg_proc    (pg_proc),
    .pg_node    (pg_node),
    .active_nxt (active_nxt),
    .underflow  (underflow)
  );

  nwt_wake_merge #(
    .NUM_PROCS(NUM_PROCS), .NUM_NODES(NUM_NODES)
  ) u_merge (
    .clk        (clk),
    .rst_n      (rst_i),
    .active_nxt (active_nxt),
    .sw_valid   (sw_valid),
    .sw_next    (sw_next),
    .sw_after   (sw_after),
    .wake_mask  (wake_mask),
    .wake_valid (wake_valid)
  );

  assign err_d = underflow;

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) unmap_err <= 1'b0;
    else unmap_err <= err_d;
  end

  p_err_cause_r5: assert property (@(posedge clk) disable iff (!rst_i)
    unmap_err |-> $past(pg_valid && pg_unmap));

  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_i |-> (!wake_valid && !unmap_err && wake_mask == '0));
endmodule

// File: tb/test_node_wake_tracker.sv
module test_node_wake_tracker;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 8;
  localparam int NN = 16;
  localparam int CW = 3;
  localparam int CMAX = (1 << CW) - 1;

  typedef struct packed {
    logic        ev;
    logic        un;
    logic [2:0]  p;
    logic [3:0]  n;
    logic        sw;
    logic [2:0]  a;
    logic [2:0]  b;
    logic [15:0] mask;
    logic        err;
    logic [3:0]  req;
  } vec_t;

  function automatic vec_t v(input bit ev, input bit un, input int p, input int n,
                             input bit sw, input int a, input int b,
                             input int mask, input bit err, input int req);
    vec_t r;
    r.ev = ev; r.un = un; r.p = 3'(p); r.n = 4'(n);
    r.sw = sw; r.a = 3'(a); r.b = 3'(b);
    r.mask = 16'(mask); r.err = err; r.req = 4'(req);
    return r;
  endfunction

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    v(1,0,1,3, 0,0,0, 16'h0000,0, 2),  // R2 map, mask untouched
    v(0,0,0,0, 1,1,1, 16'h0008,0,10),  // R10 same slot twice
    v(1,0,2,5, 1,1,2, 16'h0028,0, 8),  // R8 first map with switch
    v(1,0,1,3, 0,0,0, 16'h0028,0, 7),  // R7 hold, count 2
    v(1,1,1,3, 0,0,0, 16'h0028,0, 3),  // R3 count 1
    v(0,0,0,0, 1,1,2, 16'h0028,0, 3),  // R3 still active
    v(1,1,1,3, 0,0,0, 16'h0028,0, 3),  // R3 count 0
    v(0,0,0,0, 1,1,2, 16'h0020,0, 3),  // R3 node 3 gone
    v(1,1,1,3, 0,0,0, 16'h0020,1, 5),  // R5 unmap at zero
    v(0,0,0,0, 1,1,2, 16'h0020,0, 5),  // R5 nothing changed
    v(1,0,3,0, 1,4,5, 16'h0000,0, 9),  // R9 other slots empty
    v(1,1,2,5, 1,2,3, 16'h0001,0, 8),  // R8 last unmap with switch
    v(1,0,7,15,0,0,0, 16'h0001,0, 2),  // R2 top node
    v(0,0,0,0, 1,7,3, 16'h8001,0, 6)   // R6 union
  };

  logic clk = 1'b0;
  logic rst_n;
  logic pg_valid, pg_unmap, sw_valid;
  logic [2:0] pg_proc, sw_next, sw_after;
  logic [3:0] pg_node;
  logic [NN-1:0] wake_mask;
  logic wake_valid, unmap_err;

  int n_checks = 0;
  int n_fail = 0;
  int cycles = 0;
  logic [15:0] last_mask;

  always #(CLK_PERIOD/2) clk = ~clk;

  node_wake_tracker #(.NUM_PROCS(NP), .NUM_NODES(NN), .CNT_W(CW)) i_node_wake_tracker (
    .clk(clk), .rst_n(rst_n),
    .pg_valid(pg_valid), .pg_unmap(pg_unmap), .pg_proc(pg_proc), .pg_node(pg_node),
    .sw_valid(sw_valid), .sw_next(sw_next), .sw_after(sw_after),
    .wake_mask(wake_mask), .wake_valid(wake_valid), .unmap_err(unmap_err)
  );

  task automatic finish_run();
    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected under 20000", cycles);
      finish_run();
    end
  end

  task automatic chk(input string req, input logic [17:0] act, input logic [17:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual mask=%h valid=%b err=%b, expected mask=%h valid=%b err=%b",
               req, act[17:2], act[1], act[0], exp[17:2], exp[1], exp[0]);
    end
  endtask

  task automatic step(input vec_t x, input string req);
    @(negedge clk);
    pg_valid = x.ev; pg_unmap = x.un; pg_proc = x.p; pg_node = x.n;
    sw_valid = x.sw; sw_next = x.a; sw_after = x.b;
    @(posedge clk);
    #1;
    if (x.sw) last_mask = x.mask;
    chk(req, {wake_mask, wake_valid, unmap_err}, {last_mask, x.sw, x.err});
    @(negedge clk);
    pg_valid = 0; sw_valid = 0;
  endtask

  initial begin
    rst_n = 1'b0;
    pg_valid = 0; pg_unmap = 0; pg_proc = 0; pg_node = 0;
    sw_valid = 0; sw_next = 0; sw_after = 0;
    last_mask = '0;
    repeat (3) @(posedge clk);
    #1 chk("R1 in reset", {wake_mask, wake_valid, unmap_err}, 18'd0);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    step(v(0,0,0,0, 1,0,7, 0,0,1), "R1 counts clear after reset");

    for (int i = 0; i < NV; i++)
      step(VECS[i], $sformatf("R%0d table row %0d", VECS[i].req, i));

    // R4 saturation: nine maps on a CMAX counter, then CMAX unmaps
    for (int i = 0; i < CMAX + 2; i++)
      step(v(1,0,6,9, 1,6,6, 16'h0200,0,4), "R4 map toward saturation");
    for (int i = 0; i < CMAX - 1; i++)
      step(v(1,1,6,9, 1,6,6, 16'h0200,0,4), "R4 unmap above zero");
    step(v(1,1,6,9, 1,6,6, 16'h0000,0,4), "R4 last unmap clears node");
    step(v(1,1,6,9, 1,6,6, 16'h0000,1,4), "R4 R5 saturated count was max");

    // R1 asynchronous reset in mid-run
    @(negedge clk) rst_n = 1'b0;
    #1 chk("R1 async reset", {wake_mask, wake_valid, unmap_err}, 18'd0);
    last_mask = '0;
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    step(v(0,0,0,0, 1,7,3, 0,0,1), "R1 counts cleared by reset");

    finish_run();
  end
endmodule